// File: doc/BRIEF.md
# Set-Associative Cache Tag Model

This block models the tag side of a small first-level data cache. It stores no data. Each memory access comes in as a request with an address and a kind. The block sorts every access into hit, miss and eviction, and keeps one running counter for each of those outcomes. Parameters set the block size, the number of sets, the number of ways and the replacement rule. The default is a 256-byte cache with 16-byte blocks, 4 sets, 4 ways and least-recently-used replacement. The same module can also run as a 16-set direct-mapped cache, or as a single set of 16 ways that replaces in allocation order.

Requests use a valid/ready handshake. A combined read-modify access is looked up twice: first as a read, then as a write to the same address. A two-state controller sequences this. In `ST_IDLE` the block accepts a request (`req_ready` is high) and looks it up at once. Accepting a modify takes the transition `ST_IDLE -> ST_STORE_HALF`. In that state the held address is looked up as a write, `req_ready` is low, and the controller always returns with `ST_STORE_HALF -> ST_IDLE`. Every other request leaves it in `ST_IDLE`.

Top module: `cache_tag_model`

## Requirements
- R1: Lookup ignores the low OFFSET_BITS address bits (4 by default). Two addresses in the same 16-byte block behave as the same line, whatever the byte offset.
- R2: After reset no line is valid, all three counters read zero and `req_ready` is high. The first access to any block is a miss.
- R3: An access whose tag matches a valid line in its set gives a result with `res_hit`=1 and `res_miss`=0, and it adds one to the hit counter.
- R4: A miss in a set that still has an invalid line fills the lowest-numbered invalid way. It reports `res_miss`=1 with `res_evict`=0.
- R5: With REPL=LRU (default, 4 sets by 4 ways), a miss in a full set replaces the line whose most recent access is the oldest.
- R6: With REPL=FIFO (0 index bits, 16 ways), a miss in a full set replaces the line that was filled earliest. Hits do not change that order.
- R7: With 4 index bits and 1 way, any miss on an occupied set replaces the resident line.
- R8: `res_evict` and the eviction counter go up only when a miss replaces a valid line. They go up in the same result as the miss.
- R9: Kind 2'b10 (modify) produces two results on consecutive cycles. The first is a read lookup and the second is a write lookup of the same address. `req_ready` is low in the cycle between them.
- R10: Kind 2'b11 (instruction fetch) is accepted but produces no result and changes no counter. The other kinds are 2'b00 load and 2'b01 store.
- R11: A store allocates on a miss in the same way as a load (write-allocate), and it marks its line dirty. `res_dirty` is 1 exactly when the evicted line was dirty.
- R12: The hit, miss and eviction counters are CNT_W bits wide and hold at their maximum value instead of wrapping.
- R13: A result appears on the outputs in the cycle after its lookup. The counters already include that result in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address of the access |
| req_type | input | 2 | 00 load, 01 store, 10 modify, 11 instruction fetch |
| res_valid | output | 1 | One-cycle result pulse |
| res_hit | output | 1 | Lookup hit |
| res_miss | output | 1 | Lookup missed |
| res_evict | output | 1 | Miss replaced a valid line |
| res_dirty | output | 1 | Replaced line was dirty |
| cnt_hit | output | CNT_W | Saturating hit count |
| cnt_miss | output | CNT_W | Saturating miss count |
| cnt_evict | output | CNT_W | Saturating eviction count |

## Verification
A miss and an eviction can land in the same result. When they do, both flags and both counters must move together. The bench provokes this by filling a set to capacity and then touching one more tag. Under LRU it confirms that a recently re-read line survives. Under FIFO it confirms that a line that was hit is still the next to leave. The second pair that shares a cycle is a modify's write half and the counter update. The bench checks that this half always hits, that it follows one cycle after the read half, and that no new request is accepted in between.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD   = 2'b00,
        ACC_STORE  = 2'b01,
        ACC_MODIFY = 2'b10,
        ACC_IFETCH = 2'b11
    } acc_kind_e;

    typedef enum logic {
        REPL_LRU  = 1'b0,
        REPL_FIFO = 1'b1
    } repl_mode_e;

    typedef enum logic {
        ST_IDLE       = 1'b0,
        ST_STORE_HALF = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/cache_set_lookup.sv
module cache_set_lookup #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 26,
    parameter int WAY_W = 2,
    parameter int AGE_W = 3
) (
    input  logic [WAYS-1:0]             set_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  set_tags,
    input  logic [WAYS-1:0][AGE_W-1:0]  set_ages,
    input  logic [TAG_W-1:0]            probe_tag,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way,
    output logic [WAY_W-1:0]            victim_way,
    output logic                        victim_valid
);
    logic             free_any;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] oldest_way;

    always_comb begin
        hit        = 1'b0;
        hit_way    = '0;
        free_any   = 1'b0;
        free_way   = '0;
        oldest_way = '0;
        // descending scan so the lowest-numbered way wins
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (set_valid[w] && set_tags[w] == probe_tag) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
            if (!set_valid[w]) begin
                free_any = 1'b1;
                free_way = WAY_W'(w);
            end
            if (set_ages[w] == AGE_W'(WAYS - 1)) begin
                oldest_way = WAY_W'(w);
            end
        end
        victim_way   = free_any ? free_way : oldest_way;
        victim_valid = !free_any;
    end

endmodule

// File: rtl/cache_age_update.sv
module cache_age_update #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2,
    parameter int AGE_W = 3
) (
    input  logic [WAYS-1:0]             set_valid,
    input  logic [WAYS-1:0][AGE_W-1:0]  ages_in,
    input  logic [WAY_W-1:0]            touch_way,
    output logic [WAYS-1:0][AGE_W-1:0]  ages_out
);
    logic [AGE_W-1:0] pivot;

    always_comb begin
        // filling an invalid line ages every valid line
        pivot = set_valid[touch_way] ? ages_in[touch_way] : AGE_W'(WAYS);
        for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch_way) begin
                ages_out[w] = '0;
            end else if (set_valid[w] && ages_in[w] < pivot) begin
                ages_out[w] = ages_in[w] + 1'b1;
            end else begin
                ages_out[w] = ages_in[w];
            end
        end
    end

endmodule

// File: rtl/cache_sat_counter.sv
module cache_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bump,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (bump && count != TOP) begin
            count <= count + 1'b1;
        end
    end

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (count == TOP) |=> (count == TOP)); // R12

endmodule

// File: rtl/cache_tag_model.sv
module cache_tag_model
    import cache_tag_pkg::*;
#(
    parameter int         ADDR_W      = 32,
    parameter int         OFFSET_BITS = 4,
    parameter int         INDEX_BITS  = 2,
    parameter int         WAYS        = 4,
    parameter repl_mode_e REPL        = REPL_LRU,
    parameter int         CNT_W       = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_type,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_miss,
    output logic              res_evict,
    output logic              res_dirty,
    output logic [CNT_W-1:0]  cnt_hit,
    output logic [CNT_W-1:0]  cnt_miss,
    output logic [CNT_W-1:0]  cnt_evict
);
    localparam int NSETS = 1 << INDEX_BITS;
    localparam int TAG_W = ADDR_W - OFFSET_BITS - INDEX_BITS;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int AGE_W = $clog2(WAYS) + 1;
    localparam int SET_W = (INDEX_BITS > 0) ? INDEX_BITS : 1;

    ctl_state_e        state_q, state_d;
    acc_kind_e         kind;
    logic [ADDR_W-1:0] hold_addr_q;
    logic [ADDR_W-1:0] cur_addr;
    logic              accept, do_lookup, is_store, reorder;
    logic [SET_W-1:0]  cur_set;
    logic [TAG_W-1:0]  cur_tag;

    logic [WAYS-1:0]            valid_q [NSETS];
    logic [WAYS-1:0]            dirty_q [NSETS];
    logic [WAYS-1:0][TAG_W-1:0] tag_q   [NSETS];
    logic [WAYS-1:0][AGE_W-1:0] age_q   [NSETS];

    logic                       lk_hit, vict_valid;
    logic [WAY_W-1:0]           hit_way, vict_way, touch_way;
    logic [WAYS-1:0][AGE_W-1:0] ages_next;

    assign kind      = acc_kind_e'(req_type);
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign cur_addr  = (state_q == ST_IDLE) ? req_addr : hold_addr_q;
    assign do_lookup = (state_q == ST_STORE_HALF) || (accept && kind != ACC_IFETCH);
    assign is_store  = (state_q == ST_STORE_HALF) || (kind == ACC_STORE);
    assign cur_tag   = cur_addr[ADDR_W-1 -: TAG_W];

    generate
        if (INDEX_BITS == 0) begin : g_no_index
            assign cur_set = '0;
        end else begin : g_index
            assign cur_set = cur_addr[OFFSET_BITS +: INDEX_BITS];
        end
    endgenerate

    // controller: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (accept && kind == ACC_MODIFY) state_d = ST_STORE_HALF;
            ST_STORE_HALF: state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // controller: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            hold_addr_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) hold_addr_q <= req_addr;
        end
    end

    cache_set_lookup #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W), .AGE_W(AGE_W)) u_lookup (
        .set_valid    (valid_q[cur_set]),
        .set_tags     (tag_q[cur_set]),
        .set_ages     (age_q[cur_set]),
        .probe_tag    (cur_tag),
        .hit          (lk_hit),
        .hit_way      (hit_way),
        .victim_way   (vict_way),
        .victim_valid (vict_valid)
    );

    assign touch_way = lk_hit ? hit_way : vict_way;
    assign reorder   = do_lookup && (!lk_hit || REPL == REPL_LRU);

    cache_age_update #(.WAYS(WAYS), .WAY_W(WAY_W), .AGE_W(AGE_W)) u_age (
        .set_valid (valid_q[cur_set]),
        .ages_in   (age_q[cur_set]),
        .touch_way (touch_way),
        .ages_out  (ages_next)
    );

    // line state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                tag_q[s]   <= '0;
                age_q[s]   <= '0;
            end
        end else if (do_lookup) begin
            valid_q[cur_set][touch_way] <= 1'b1;
            tag_q[cur_set][touch_way]   <= cur_tag;
            dirty_q[cur_set][touch_way] <= is_store || (lk_hit && dirty_q[cur_set][touch_way]);
            if (reorder) age_q[cur_set] <= ages_next;
        end
    end

    // outputs: one-cycle result pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_miss  <= 1'b0;
            res_evict <= 1'b0;
            res_dirty <= 1'b0;
        end else begin
            res_valid <= do_lookup;
            res_hit   <= do_lookup && lk_hit;
            res_miss  <= do_lookup && !lk_hit;
            res_evict <= do_lookup && !lk_hit && vict_valid;
            res_dirty <= do_lookup && !lk_hit && vict_valid && dirty_q[cur_set][vict_way];
        end
    end

    logic [2:0]       cnt_bump;
    logic [CNT_W-1:0] cnt_val [3];

    assign cnt_bump = {do_lookup && !lk_hit && vict_valid, do_lookup && !lk_hit, do_lookup && lk_hit};

    generate
        for (genvar k = 0; k < 3; k++) begin : g_cnt
            cache_sat_counter #(.W(CNT_W)) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .bump  (cnt_bump[k]),
                .count (cnt_val[k])
            );
        end
    endgenerate

    assign cnt_hit   = cnt_val[0];
    assign cnt_miss  = cnt_val[1];
    assign cnt_evict = cnt_val[2];

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $onehot({res_hit, res_miss})); // R3
    AST_EVICT_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        res_evict |-> (res_valid && res_miss)); // R8
    AST_DIRTY_ON_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
        res_dirty |-> res_evict); // R11
    AST_MODIFY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind == ACC_MODIFY) |=> (res_valid && !req_ready) ##1 (res_valid && res_hit)); // R9
    AST_FETCH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind == ACC_IFETCH) |=> (!res_valid && $stable(cnt_hit) && $stable(cnt_miss))); // R10
    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind != ACC_IFETCH) |=> res_valid); // R13

endmodule

// File: tb/cache_tag_model_tb.sv
`timescale 1ns/1ps
module cache_tag_model_tb;
    import cache_tag_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  vld = '0;
    logic [31:0] addr = '0;
    logic [1:0]  kind = 2'b00;

    logic        rdy [3];
    logic        rv [3], rh [3], rm [3], re [3], rd [3];
    logic [31:0] ch [3], cm [3], ce [3];
    logic [4:0]  n_ch, n_cm, n_ce;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        int    unit;
        logic  h, m, e, d;
        string req;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    // unit 0: default 4x4 LRU with narrow counters for saturation
    cache_tag_model #(.CNT_W(5)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(vld[0]), .req_ready(rdy[0]),
        .req_addr(addr), .req_type(kind), .res_valid(rv[0]), .res_hit(rh[0]),
        .res_miss(rm[0]), .res_evict(re[0]), .res_dirty(rd[0]),
        .cnt_hit(n_ch), .cnt_miss(n_cm), .cnt_evict(n_ce));
    assign ch[0] = {27'b0, n_ch};
    assign cm[0] = {27'b0, n_cm};
    assign ce[0] = {27'b0, n_ce};

    // unit 1: one set, 16 ways, FIFO
    cache_tag_model #(.INDEX_BITS(0), .WAYS(16), .REPL(REPL_FIFO)) u_fa (
        .clk(clk), .rst_n(rst_n), .req_valid(vld[1]), .req_ready(rdy[1]),
        .req_addr(addr), .req_type(kind), .res_valid(rv[1]), .res_hit(rh[1]),
        .res_miss(rm[1]), .res_evict(re[1]), .res_dirty(rd[1]),
        .cnt_hit(ch[1]), .cnt_miss(cm[1]), .cnt_evict(ce[1]));

    // unit 2: 16 sets, direct mapped
    cache_tag_model #(.INDEX_BITS(4), .WAYS(1)) u_dm (
        .clk(clk), .rst_n(rst_n), .req_valid(vld[2]), .req_ready(rdy[2]),
        .req_addr(addr), .req_type(kind), .res_valid(rv[2]), .res_hit(rh[2]),
        .res_miss(rm[2]), .res_evict(re[2]), .res_dirty(rd[2]),
        .cnt_hit(ch[2]), .cnt_miss(cm[2]), .cnt_evict(ce[2]));

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: pop and compare each result
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && !done) begin
            for (int u = 0; u < 3; u++) begin
                if (rv[u]) begin
                    if (q.size() == 0) begin
                        chk("R10", "unexpected result on unit", u, -1);
                    end else begin
                        e = q.pop_front();
                        chk(e.req, "unit", u, e.unit);
                        chk(e.req, "hit", rh[u], e.h);
                        chk(e.req, "miss", rm[u], e.m);
                        chk(e.req, "evict", re[u], e.e);
                        chk(e.req, "dirty", rd[u], e.d);
                    end
                end
            end
        end
    end

    // driver: push expectations, then hand the request over
    task automatic send(input int u, input logic [31:0] a, input logic [1:0] t,
                        input logic h, input logic m, input logic e, input logic d,
                        input string req);
        exp_t x;
        if (t != 2'b11) begin
            x.unit = u; x.h = h; x.m = m; x.e = e; x.d = d; x.req = req;
            q.push_back(x);
        end
        if (t == 2'b10) begin
            x.unit = u; x.h = 1'b1; x.m = 1'b0; x.e = 1'b0; x.d = 1'b0; x.req = "R9";
            q.push_back(x);
        end
        @(negedge clk);
        while (!rdy[u]) @(negedge clk);
        addr = a;
        kind = t;
        vld[u] = 1'b1;
        @(negedge clk);
        vld[u] = 1'b0;
        if (t == 2'b10) chk("R9", "ready during write half", rdy[u], 0);
    endtask

    task automatic counts(input int u, input int h, input int m, input int e, input string req);
        repeat (3) @(negedge clk);
        chk(req, "hit count", ch[u], h);
        chk(req, "miss count", cm[u], m);
        chk(req, "evict count", ce[u], e);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int u = 0; u < 3; u++) begin
            chk("R2", "ready after reset", rdy[u], 1);
            chk("R2", "result after reset", rv[u], 0);
            chk("R2", "hit count", ch[u], 0);
            chk("R2", "miss count", cm[u], 0);
            chk("R2", "evict count", ce[u], 0);
        end

        // ---- unit 0: LRU, 4 sets x 4 ways ----
        send(0, 32'h000, 2'b00, 0, 1, 0, 0, "R2");
        send(0, 32'h004, 2'b00, 1, 0, 0, 0, "R1");
        send(0, 32'h00C, 2'b01, 1, 0, 0, 0, "R3");   // marks block dirty
        send(0, 32'h040, 2'b00, 0, 1, 0, 0, "R4");
        send(0, 32'h080, 2'b00, 0, 1, 0, 0, "R4");
        send(0, 32'h0C0, 2'b00, 0, 1, 0, 0, "R4");
        counts(0, 2, 4, 0, "R4");
        send(0, 32'h000, 2'b00, 1, 0, 0, 0, "R5");   // refresh
        send(0, 32'h100, 2'b00, 0, 1, 1, 0, "R8");   // evicts 0x040
        send(0, 32'h040, 2'b00, 0, 1, 1, 0, "R5");   // evicts 0x080
        send(0, 32'h000, 2'b00, 1, 0, 0, 0, "R5");   // recently used survives
        send(0, 32'h140, 2'b00, 0, 1, 1, 0, "R5");
        send(0, 32'h180, 2'b00, 0, 1, 1, 0, "R5");
        send(0, 32'h1C0, 2'b00, 0, 1, 1, 0, "R5");
        send(0, 32'h200, 2'b00, 0, 1, 1, 1, "R11");  // evicts dirty 0x000
        counts(0, 4, 10, 6, "R8");
        send(0, 32'h300, 2'b11, 0, 0, 0, 0, "R10");
        counts(0, 4, 10, 6, "R10");
        send(0, 32'h800, 2'b10, 0, 1, 1, 0, "R9");
        send(0, 32'h010, 2'b01, 0, 1, 0, 0, "R11");  // store miss allocates
        send(0, 32'h018, 2'b00, 1, 0, 0, 0, "R11");
        counts(0, 6, 12, 7, "R13");
        for (int i = 0; i < 30; i++) send(0, 32'h010, 2'b00, 1, 0, 0, 0, "R12");
        counts(0, 31, 12, 7, "R12");

        // ---- unit 1: FIFO, one set x 16 ways ----
        for (int i = 0; i < 16; i++) send(1, 32'(i * 16), 2'b00, 0, 1, 0, 0, "R4");
        send(1, 32'h000, 2'b00, 1, 0, 0, 0, "R6");   // hit does not reorder
        send(1, 32'h100, 2'b00, 0, 1, 1, 0, "R6");   // evicts block 0
        send(1, 32'h000, 2'b00, 0, 1, 1, 0, "R6");   // evicts block 1
        send(1, 32'h010, 2'b00, 0, 1, 1, 0, "R6");   // evicts block 2
        counts(1, 1, 19, 3, "R6");

        // ---- unit 2: direct mapped, 16 sets ----
        send(2, 32'h000, 2'b00, 0, 1, 0, 0, "R7");
        send(2, 32'h100, 2'b00, 0, 1, 1, 0, "R7");
        send(2, 32'h200, 2'b01, 0, 1, 1, 0, "R7");
        send(2, 32'h010, 2'b00, 0, 1, 0, 0, "R7");
        send(2, 32'h208, 2'b00, 1, 0, 0, 0, "R7");
        send(2, 32'h000, 2'b00, 0, 1, 1, 1, "R11");
        counts(2, 1, 5, 3, "R7");

        chk("R13", "results outstanding", q.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule